// File: doc/BRIEF.md
# Link Utilization Counters

This block gathers loading statistics for a link allocator that shares a small set of serial links among a larger set of requesting channels. Each channel has a saturating counter. A common tick samples a chosen activity signal, and the counter advances on every tick where that signal is high. The counting runs over a gate window whose length software chooses, short or long. The long window also uses a coarser tick.

When a window closes, every counter copies its total into a holding register and starts again from zero in the same clock cycle. A per-counter "fresh" flag is raised at that moment and drops once software has read the holding register.

Software uses a single-cycle register port, which has these outputs:
- read data;
- a response bit that carries the addressed counter's fresh flag;
- a valid bit that is driven only for existing register and access combinations.

An inhibit input switches off all decoding. A clear input returns the control register to its default and restarts the counting.

Top module: `ulc_link_stats`

## Requirements
- R1: Address map and control encoding. Addresses 0 to NUM_CH-1 are read-only holding registers. Address NUM_CH is the read/write control register, read back in the low three bits of the read data. Control bit 0 selects the long gate (1) or the short gate (0). Control bits 2:1 select the source: 00 link grant, 01 channel grant, 10 channel request, 11 test count (always active).
- R2: After a restart, the short gate samples in every CLK_PER_US-th cycle. The long gate samples every CLK_PER_US*LONG_US_PER_TICK cycles. The first sample falls on the last cycle of the first tick interval.
- R3: A window closes on its SHORT_GATE_TICKS-th (or LONG_GATE_TICKS-th) tick. That tick's sample is part of the copied total, and the counter restarts from zero in the same cycle.
- R4: A counter holds at all-ones and does not wrap.
- R5: In channel-grant and channel-request modes, counter i samples the channel-i grant or request. In test-count mode, every counter samples a constant one.
- R6: In link-grant mode, counter i < NUM_LINK samples the OR, over all channels, of that channel's grant when its 2-bit link address (ch_link bits 2c+1:2c) equals i. Counters at or above NUM_LINK count as in test-count mode.
- R7: All fresh flags are set when a window closes. A read returns the addressed holding value, with acc_resp equal to its fresh flag. That flag is clear from the next cycle on. A control access returns acc_resp = 1.
- R8: When a window closes in the same cycle as a holding read, the read returns the previous value with its previous flag, and the flag ends up set.
- R9: An accepted control write loads the register, zeroes every counter and fresh flag, and restarts the tick and gate timing. Holding values are kept.
- R10: A clear pulse zeroes the control register and every counter and restarts the timing. Holding values and fresh flags are kept. Clear takes priority over a write in the same cycle.
- R11: After reset, all holding values, flags and the control register are zero.
- R12: While inhibit is high, acc_valid, acc_resp and acc_rdata are zero. In that state, writes are ignored and reads clear no flag.
- R13: acc_valid is high only for a read of addresses 0 to NUM_CH, or a write to address NUM_CH. Any other access changes nothing. A write has priority over a simultaneous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_req | input | NUM_CH | Per-channel request |
| ch_gnt | input | NUM_CH | Per-channel grant |
| ch_link | input | NUM_CH*$clog2(NUM_LINK) | Link address granted to each channel |
| clear | input | 1 | Clear counters and control register |
| inhibit | input | 1 | Disable register decoding |
| acc_rd | input | 1 | Register read in this cycle |
| acc_wr | input | 1 | Register write in this cycle |
| acc_addr | input | ADDR_W | Register address |
| acc_wdata | input | 3 | Control write data |
| acc_rdata | output | CNT_W | Register read data |
| acc_resp | output | 1 | Response: fresh flag of the addressed counter |
| acc_valid | output | 1 | Addressed register and access exist |

## Verification
The close of a gate window and a software read of the same holding register can fall in one clock cycle. The close writes a new total and raises the flag, while the read tries to drop that flag. The bench starts a window with a control write, so the closing cycle is known exactly. It lets one window fill with activity and a second window stay idle, then places a read precisely on the second window's closing cycle. It judges the result by three back-to-back reads: the old total with the flag set, then the new total with the flag still set, and then the flag cleared.

// File: rtl/ulc_pkg.sv
package ulc_pkg;
   localparam int CTRL_W = 3;

   typedef enum logic [1:0] {
      SRC_LINK_GNT = 2'd0,
      SRC_CH_GNT   = 2'd1,
      SRC_CH_REQ   = 2'd2,
      SRC_ALWAYS   = 2'd3
   } src_sel_e;

   // bits 2:1 source, bit 0 long gate
   typedef struct packed {
      src_sel_e src;
      logic     long_gate;
   } ctrl_t;
endpackage

// File: rtl/ulc_timebase.sv
module ulc_timebase #(
   parameter int CLK_PER_US       = 10,
   parameter int LONG_US_PER_TICK = 4,
   parameter int SHORT_GATE_TICKS = 1_000_000,
   parameter int LONG_GATE_TICKS  = 15_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic long_sel,
   output logic tick,
   output logic gate_end
);
   localparam int DIV_SHORT = CLK_PER_US;
   localparam int DIV_LONG  = CLK_PER_US * LONG_US_PER_TICK;
   localparam int PRE_W     = $clog2(DIV_LONG + 1);
   localparam int GATE_TOP  = (LONG_GATE_TICKS > SHORT_GATE_TICKS) ? LONG_GATE_TICKS : SHORT_GATE_TICKS;
   localparam int GATE_W    = $clog2(GATE_TOP + 1);

   logic              tick_raw;
   logic [GATE_W-1:0] gate_q;
   logic [GATE_W-1:0] gate_last;

   generate
      if (DIV_LONG == 1) begin : g_no_prescale
         assign tick_raw = 1'b1;
      end else begin : g_prescale
         logic [PRE_W-1:0] pre_q;
         logic [PRE_W-1:0] div_last;
         assign div_last = long_sel ? PRE_W'(DIV_LONG - 1) : PRE_W'(DIV_SHORT - 1);
         assign tick_raw = (pre_q == div_last);
         always_ff @(posedge clk) begin
            if (!rst_n || restart || tick_raw) pre_q <= '0;
            else                               pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate

   assign gate_last = long_sel ? GATE_W'(LONG_GATE_TICKS - 1) : GATE_W'(SHORT_GATE_TICKS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || restart)   gate_q <= '0;
      else if (tick_raw) begin
         if (gate_q == gate_last) gate_q <= '0;
         else                     gate_q <= gate_q + 1'b1;
      end
   end

   assign tick     = tick_raw && !restart;
   assign gate_end = tick && (gate_q == gate_last);
endmodule

// File: rtl/ulc_activity_sel.sv
module ulc_activity_sel
   import ulc_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int NUM_LINK = 4
) (
   input  src_sel_e                           src,
   input  logic [NUM_CH-1:0]                  ch_req,
   input  logic [NUM_CH-1:0]                  ch_gnt,
   input  logic [NUM_CH*$clog2(NUM_LINK)-1:0] ch_link,
   output logic [NUM_CH-1:0]                  sample
);
   localparam int AW = $clog2(NUM_LINK);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic link_act;
      if (i < NUM_LINK) begin : g_link
         always_comb begin
            link_act = 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
               if (ch_gnt[c] && (ch_link[c*AW +: AW] == AW'(i))) link_act = 1'b1;
            end
         end
      end else begin : g_test
         assign link_act = 1'b1;
      end

      always_comb begin
         unique case (src)
            SRC_LINK_GNT: sample[i] = link_act;
            SRC_CH_GNT:   sample[i] = ch_gnt[i];
            SRC_CH_REQ:   sample[i] = ch_req[i];
            default:      sample[i] = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/ulc_counter_slot.sv
module ulc_counter_slot #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             gate_end,
   input  logic             restart,
   input  logic             flag_clr,
   input  logic             rd_clr,
   input  logic             sample,
   output logic [CNT_W-1:0] hold,
   output logic             flag
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             inc;

   assign inc     = tick && sample && !(&cnt_q);
   assign cnt_nxt = cnt_q + {{(CNT_W-1){1'b0}}, inc};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         hold  <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (gate_end) begin
         hold  <= cnt_nxt;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flag_clr) flag <= 1'b0;
      else if (gate_end)      flag <= 1'b1;
      else if (rd_clr)        flag <= 1'b0;
   end
endmodule

// File: rtl/ulc_regif.sv
module ulc_regif
   import ulc_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CNT_W  = 24,
   parameter int ADDR_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clear,
   input  logic                          inhibit,
   input  logic                          acc_rd,
   input  logic                          acc_wr,
   input  logic [ADDR_W-1:0]             acc_addr,
   input  logic [CTRL_W-1:0]             acc_wdata,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  holds,
   input  logic [NUM_CH-1:0]             flags,
   output ctrl_t                         ctrl_q,
   output logic                          ctrl_wr,
   output logic [NUM_CH-1:0]             rd_clr,
   output logic [CNT_W-1:0]              acc_rdata,
   output logic                          acc_resp,
   output logic                          acc_valid
);
   logic hit_ctrl, hit_hold, wr_ok, rd_ok;

   assign hit_ctrl = (acc_addr == ADDR_W'(NUM_CH));
   assign hit_hold = (acc_addr <  ADDR_W'(NUM_CH));
   assign wr_ok    = !inhibit && acc_wr && hit_ctrl;
   assign rd_ok    = !inhibit && !acc_wr && acc_rd && (hit_ctrl || hit_hold);
   assign ctrl_wr  = wr_ok && !clear;
   assign acc_valid = wr_ok || rd_ok;

   always_comb begin
      acc_rdata = '0;
      acc_resp  = 1'b0;
      rd_clr    = '0;
      if (rd_ok && hit_ctrl) begin
         acc_rdata = CNT_W'(ctrl_q);
         acc_resp  = 1'b1;
      end else if (wr_ok) begin
         acc_resp  = 1'b1;
      end
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_ok && (acc_addr == ADDR_W'(i))) begin
            acc_rdata = holds[i];
            acc_resp  = flags[i];
            rd_clr[i] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) ctrl_q <= '0;
      else if (wr_ok)      ctrl_q <= ctrl_t'(acc_wdata);
   end
endmodule

// File: rtl/ulc_link_stats.sv
module ulc_link_stats
   import ulc_pkg::*;
#(
   parameter int NUM_CH           = 8,
   parameter int NUM_LINK         = 4,
   parameter int CNT_W            = 24,
   parameter int ADDR_W           = 4,
   parameter int CLK_PER_US       = 10,
   parameter int LONG_US_PER_TICK = 4,
   parameter int SHORT_GATE_TICKS = 1_000_000,
   parameter int LONG_GATE_TICKS  = 15_000_000
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_CH-1:0]                   ch_req,
   input  logic [NUM_CH-1:0]                   ch_gnt,
   input  logic [NUM_CH*$clog2(NUM_LINK)-1:0]  ch_link,
   input  logic                                clear,
   input  logic                                inhibit,
   input  logic                                acc_rd,
   input  logic                                acc_wr,
   input  logic [ADDR_W-1:0]                   acc_addr,
   input  logic [ulc_pkg::CTRL_W-1:0]          acc_wdata,
   output logic [CNT_W-1:0]                    acc_rdata,
   output logic                                acc_resp,
   output logic                                acc_valid
);
   generate
      if (NUM_LINK < 2 || NUM_LINK > NUM_CH) begin : g_bad_links
         $error("NUM_LINK must lie in 2..NUM_CH");
      end
      if ((1 << ADDR_W) <= NUM_CH) begin : g_bad_addr
         $error("ADDR_W too narrow for NUM_CH holding registers plus control");
      end
      if (CNT_W < 2 || CLK_PER_US < 1 || LONG_US_PER_TICK < 1) begin : g_bad_width
         $error("CNT_W, CLK_PER_US and LONG_US_PER_TICK out of range");
      end
      if (SHORT_GATE_TICKS < 2 || LONG_GATE_TICKS < 2) begin : g_bad_gate
         $error("gate windows need at least two ticks");
      end
   endgenerate

   ctrl_t                        ctrl_q;
   logic                         ctrl_wr;
   logic                         restart;
   logic                         tick;
   logic                         gate_end;
   logic [NUM_CH-1:0]            sample;
   logic [NUM_CH-1:0]            rd_clr;
   logic [NUM_CH-1:0]            flag_q;
   logic [NUM_CH-1:0][CNT_W-1:0] hold_q;

   assign restart = clear || ctrl_wr;

   ulc_timebase #(
      .CLK_PER_US       (CLK_PER_US),
      .LONG_US_PER_TICK (LONG_US_PER_TICK),
      .SHORT_GATE_TICKS (SHORT_GATE_TICKS),
      .LONG_GATE_TICKS  (LONG_GATE_TICKS)
   ) i_timebase (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .long_sel (ctrl_q.long_gate),
      .tick     (tick),
      .gate_end (gate_end)
   );

   ulc_activity_sel #(
      .NUM_CH   (NUM_CH),
      .NUM_LINK (NUM_LINK)
   ) i_activity (
      .src     (ctrl_q.src),
      .ch_req  (ch_req),
      .ch_gnt  (ch_gnt),
      .ch_link (ch_link),
      .sample  (sample)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
      ulc_counter_slot #(.CNT_W(CNT_W)) i_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .gate_end (gate_end),
         .restart  (restart),
         .flag_clr (ctrl_wr),
         .rd_clr   (rd_clr[i]),
         .sample   (sample[i]),
         .hold     (hold_q[i]),
         .flag     (flag_q[i])
      );
   end

   ulc_regif #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W)
   ) i_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .inhibit   (inhibit),
      .acc_rd    (acc_rd),
      .acc_wr    (acc_wr),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .holds     (hold_q),
      .flags     (flag_q),
      .ctrl_q    (ctrl_q),
      .ctrl_wr   (ctrl_wr),
      .rd_clr    (rd_clr),
      .acc_rdata (acc_rdata),
      .acc_resp  (acc_resp),
      .acc_valid (acc_valid)
   );
endmodule

// File: rtl/ulc_link_stats_chk.sv
module ulc_link_stats_chk #(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clear,
   input logic              inhibit,
   input logic              acc_rd,
   input logic              acc_wr,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_valid,
   input logic              acc_resp,
   input logic [NUM_CH-1:0] flags,
   input logic              gate_end,
   input logic [2:0]        ctrl
);
   // R12
   inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit |-> (!acc_valid && !acc_resp));

   // R13
   valid_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> (acc_rd || acc_wr));

   // R7
   gate_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_end |=> (flags == {NUM_CH{1'b1}}));

   // R9
   ctrl_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_wr && !clear) |=> (flags == '0));

   // R10
   clear_zeroes_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (ctrl == 3'd0));

   // R3
   gate_end_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_end |=> !gate_end);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_rd
      // R7
      read_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid && !acc_wr && (acc_addr == ADDR_W'(i)) && !gate_end) |=> !flags[i]);
   end
endmodule

bind ulc_link_stats ulc_link_stats_chk #(
   .NUM_CH (NUM_CH),
   .ADDR_W (ADDR_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clear     (clear),
   .inhibit   (inhibit),
   .acc_rd    (acc_rd),
   .acc_wr    (acc_wr),
   .acc_addr  (acc_addr),
   .acc_valid (acc_valid),
   .acc_resp  (acc_resp),
   .flags     (flag_q),
   .gate_end  (gate_end),
   .ctrl      (ctrl_q)
);

// File: tb/test_ulc_link_stats.sv
module test_ulc_link_stats;
   localparam int CLK_PERIOD = 10;
   localparam int NCH   = 8;
   localparam int CW    = 4;
   localparam int AW    = 4;
   localparam int SHORT = 6;
   localparam int LONG  = 20;
   localparam int CTRL_ADDR = NCH;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NCH-1:0]  ch_req = '0;
   logic [NCH-1:0]  ch_gnt = '0;
   logic [2*NCH-1:0] ch_link = '0;
   logic            clear = 1'b0;
   logic            inhibit = 1'b0;
   logic            acc_rd = 1'b0;
   logic            acc_wr = 1'b0;
   logic [AW-1:0]   acc_addr = '0;
   logic [2:0]      acc_wdata = '0;
   logic [CW-1:0]   acc_rdata;
   logic            acc_resp;
   logic            acc_valid;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ulc_link_stats #(
      .NUM_CH(NCH), .NUM_LINK(4), .CNT_W(CW), .ADDR_W(AW),
      .CLK_PER_US(2), .LONG_US_PER_TICK(4),
      .SHORT_GATE_TICKS(SHORT), .LONG_GATE_TICKS(LONG)
   ) i_ulc_link_stats (
      .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_gnt(ch_gnt), .ch_link(ch_link),
      .clear(clear), .inhibit(inhibit), .acc_rd(acc_rd), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .acc_resp(acc_resp), .acc_valid(acc_valid)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input int addr, input int exp_d, input int exp_q, input string tag);
      acc_rd = 1'b1;
      acc_addr = AW'(addr);
      #1;
      chk(tag, "valid", int'(acc_valid), 1);
      chk(tag, $sformatf("data@%0d", addr), int'(acc_rdata), exp_d);
      chk(tag, $sformatf("resp@%0d", addr), int'(acc_resp), exp_q);
      @(negedge clk);
      acc_rd = 1'b0;
   endtask

   task automatic wr_ctrl(input logic [2:0] v);
      acc_wr = 1'b1;
      acc_addr = AW'(CTRL_ADDR);
      acc_wdata = v;
      @(negedge clk);
      acc_wr = 1'b0;
   endtask

   // R11 reset state, R1 control readback
   task automatic t_reset;
      for (int i = 0; i < NCH; i++) rd(i, 0, 0, "R11");
      rd(CTRL_ADDR, 0, 1, "R11_R1");
   endtask

   // R5 test count, R3 window length, R7 flag set then cleared by read, R9 write
   task automatic t_test_count;
      wr_ctrl(3'b110);
      idle(12);
      for (int i = 0; i < NCH; i++) rd(i, SHORT, 1, "R5_R3_R7");
      rd(0, SHORT, 0, "R7");
   endtask

   // R5 channel grant
   task automatic t_ch_grant;
      ch_gnt = 8'b1010_0101;
      wr_ctrl(3'b010);
      rd(0, SHORT, 0, "R9");
      idle(11);
      for (int i = 0; i < NCH; i++) rd(i, ch_gnt[i] ? SHORT : 0, 1, "R5");
      ch_gnt = '0;
   endtask

   // R2 short tick phase, R5 channel request
   task automatic t_ch_req;
      ch_req = 8'b1000_0010;
      wr_ctrl(3'b100);
      idle(6);
      ch_req = 8'b1000_0000;
      idle(6);
      for (int i = 0; i < NCH; i++)
         rd(i, (i == 1) ? 3 : ((i == 7) ? SHORT : 0), 1, "R2_R5");
      ch_req = '0;
   endtask

   // R6 link grant mode
   task automatic t_link;
      ch_link[11:10] = 2'd2;
      ch_link[1:0]   = 2'd1;
      ch_link[7:6]   = 2'd0;
      ch_gnt = 8'b0010_1000;
      wr_ctrl(3'b000);
      idle(12);
      for (int i = 0; i < NCH; i++)
         rd(i, (i == 0 || i == 2 || i >= 4) ? SHORT : 0, 1, "R6");
      ch_gnt = '0;
      ch_link = '0;
   endtask

   // R2 long tick, R3 long window, R4 saturation
   task automatic t_long;
      ch_req = 8'b0100_1000;
      wr_ctrl(3'b101);
      idle(8);
      ch_req = 8'b0000_1000;
      idle(150);
      rd(3, 0, 0, "R3");
      idle(1);
      rd(3, 15, 1, "R4");
      rd(6, 1, 1, "R2");
      ch_req = '0;
   endtask

   // R12 inhibit
   task automatic t_inhibit;
      inhibit = 1'b1;
      acc_rd = 1'b1;
      acc_addr = 4'd0;
      #1;
      chk("R12", "valid", int'(acc_valid), 0);
      chk("R12", "resp", int'(acc_resp), 0);
      chk("R12", "data", int'(acc_rdata), 0);
      @(negedge clk);
      acc_rd = 1'b0;
      acc_wr = 1'b1;
      acc_addr = AW'(CTRL_ADDR);
      acc_wdata = 3'b110;
      #1;
      chk("R12", "wr valid", int'(acc_valid), 0);
      @(negedge clk);
      acc_wr = 1'b0;
      inhibit = 1'b0;
      rd(CTRL_ADDR, 5, 1, "R12");
      rd(0, 0, 1, "R12");
   endtask

   // R13 nonexistent accesses
   task automatic t_invalid;
      acc_rd = 1'b1;
      acc_addr = 4'd9;
      #1;
      chk("R13", "valid", int'(acc_valid), 0);
      chk("R13", "data", int'(acc_rdata), 0);
      @(negedge clk);
      acc_rd = 1'b0;
      acc_wr = 1'b1;
      acc_addr = 4'd4;
      acc_wdata = 3'b010;
      #1;
      chk("R13", "wr valid", int'(acc_valid), 0);
      @(negedge clk);
      acc_wr = 1'b0;
      rd(CTRL_ADDR, 5, 1, "R13");
      rd(4, 0, 1, "R13");
   endtask

   // R10 clear restarts timing and zeroes control
   task automatic t_clear;
      ch_req = 8'hFF;
      wr_ctrl(3'b100);
      idle(4);
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      idle(10);
      rd(4, 0, 0, "R10");
      idle(1);
      rd(CTRL_ADDR, 0, 1, "R10");
      rd(4, SHORT, 1, "R10");
      rd(0, 0, 1, "R10");
      ch_req = '0;
   endtask

   // R8 window close coincides with a holding read
   task automatic t_collide;
      ch_req = 8'b0000_0100;
      wr_ctrl(3'b100);
      idle(12);
      ch_req = '0;
      idle(11);
      rd(2, SHORT, 1, "R8");
      rd(2, 0, 1, "R8");
      rd(2, 0, 0, "R8");
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      t_reset();
      t_test_count();
      t_ch_grant();
      t_ch_req();
      t_link();
      t_long();
      t_inhibit();
      t_invalid();
      t_clear();
      t_collide();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule